// File: doc/BRIEF.md
# Watchdog Timer with Protected Count Clock

This block is a down-counting watchdog. It reloads to its full count at reset and on every valid refresh, counts ticks, and raises a one-cycle system reset request (or an interrupt pulse, when software has picked the interrupt response) when the count passes zero. Software reaches it through a small write-only register port with four locations. A refresh is accepted only when an arming value 00h and then a firing value FFh are written to the refresh location, in that order.

Two configuration straps are sampled while reset is held and cannot be changed by software. The start strap decides whether counting begins right after reset (strap low) or waits for any write to the start location (strap high). The protection strap, when low, turns on a protection mode. Software can also turn this mode on through a sticky bit. In protection mode:
- counting uses the low-speed oscillator tick, not the CPU tick;
- the oscillator enable is held on;
- stop-mode selection is masked;
- writes to the clock control and response-mode controls are ignored;
- underflow always requests a reset.

All logic runs on one system clock. Both count sources arrive as single-cycle tick strobes, so a halted CPU tick cannot stall a protected count.

Top module: `wdt_guard`

## Requirements
- R1: While reset is held, and in the cycle after it is released, count reads FFFh, rst_req and uf_irq are 0, lso_en is 1, stop_mode_en is 0 and rst_on_uf is 1.
- R2: With strap_start_n sampled as 0, running is 1 after reset and the count falls by one on each selected tick. With strap_start_n sampled as 1, running is 0 and the count holds at FFFh until a write to location 1, the start location. That write sets running without a decrement in the same cycle.
- R3: A write of 00h to location 0 arms the refresh. A later write of FFh to location 0 reloads the count to FFFh in the clock of that write. Writes to other locations, and repeated 00h writes to location 0, leave the block armed.
- R4: A write of FFh to location 0 while not armed does not reload the count. Any write to location 0 of a value other than 00h clears the armed state.
- R5: On the 4096th selected tick after a reload, rst_req pulses for exactly one cycle if rst_on_uf is 1, or uf_irq pulses if it is 0. The count reads FFFh in that same cycle.
- R6: Outside protection, bit 2 of location 2 selects the count tick: 1 selects lso_tick and 0 selects cpu_tick. In protection mode only lso_tick decrements the count.
- R7: Protection is active when strap_prot_n was sampled 0 during reset, or after a write to location 3 with bit 1 set. The active state is sticky until reset. Entry by software reloads the count to FFFh, sets running and forces lso_en to 1.
- R8: Outside protection, bit 0 of location 2 turns the oscillator off (lso_en = 0) and bit 1 selects stop mode (stop_mode_en = 1). In protection mode, writes to location 2 are ignored, lso_en stays 1 and stop_mode_en is 0.
- R9: Outside protection, bit 0 of location 3 sets rst_on_uf. In protection mode, rst_on_uf reads 1 and writes to that bit are ignored.
- R10: A change on either strap after reset release has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are sampled while it is low |
| strap_start_n | input | 1 | Start strap: 0 starts counting after reset, 1 waits for a start write |
| strap_prot_n | input | 1 | Protection strap: 0 enables protection mode |
| cpu_tick | input | 1 | Count strobe derived from the CPU clock |
| lso_tick | input | 1 | Count strobe from the low-speed oscillator |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Location: 0 refresh, 1 start, 2 clock control, 3 mode |
| wr_data | input | 8 | Write data |
| count | output | CNT_W | Current counter value |
| running | output | 1 | Counter is running |
| rst_req | output | 1 | One-cycle watchdog reset request |
| uf_irq | output | 1 | One-cycle underflow interrupt when the reset response is off |
| protect_active | output | 1 | Protection mode is in force |
| lso_en | output | 1 | Low-speed oscillator enable |
| stop_mode_en | output | 1 | Stop mode is selected and permitted |
| rst_on_uf | output | 1 | Effective reset-on-underflow setting |

## Verification
The refresh checker is driven with the correct arm-then-fire pair and with several near misses: a lone fire, a fire after a foreign value, a fire after writes to other locations, and a fire after a doubled arm. Together these separate a sequence that tracks only the last write from one that tracks only the last write to the refresh location. Underflow is timed from a refresh, from a start write, and from the first oscillator tick under the protection strap; this shows that the period is 4096 ticks and that the correct pulse fires. Writes to the locked controls are repeated with protection off and then on, so a lock that never engages is told apart from one that always does.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;
    localparam int ADDR_W = 2;
    localparam int DATA_W = 8;

    typedef enum logic [ADDR_W-1:0] {
        REG_KICK  = 2'd0,
        REG_START = 2'd1,
        REG_CTRL  = 2'd2,
        REG_MODE  = 2'd3
    } reg_sel_e;

    localparam int CTRL_OSC_OFF  = 0;
    localparam int CTRL_STOP_SEL = 1;
    localparam int CTRL_SRC_LSO  = 2;
    localparam int MODE_RST      = 0;
    localparam int MODE_PROT     = 1;
    localparam int CFG_BITS      = 3;

    localparam logic [DATA_W-1:0] KICK_ARM  = 8'h00;
    localparam logic [DATA_W-1:0] KICK_FIRE = 8'hFF;
endpackage

// File: rtl/wdt_kick_seq.sv
module wdt_kick_seq
    import wdt_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              refresh
);
    typedef struct packed {
        logic armed;
    } seq_t;

    seq_t s_d, s_q;
    logic wr_kick;

    always_comb begin
        wr_kick = wr_en && (wr_addr == REG_KICK);
        refresh = wr_kick && s_q.armed && (wr_data == KICK_FIRE);
        s_d = s_q;
        if (wr_kick) begin
            s_d.armed = (wr_data == KICK_ARM);
        end
        if (!rst_n) begin
            s_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    // R4: a non-arming write to the refresh location drops the armed state
    assert_disarm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_kick && wr_data != KICK_ARM) |=> !s_q.armed);
endmodule

// File: rtl/wdt_ctrl_regs.sv
module wdt_ctrl_regs
    import wdt_guard_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                strap_prot_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [CFG_BITS-1:0] wr_bits,
    output logic                protect,
    output logic                osc_off,
    output logic                stop_sel,
    output logic                src_lso,
    output logic                rst_mode,
    output logic                start_pulse,
    output logic                prot_entry
);
    typedef struct packed {
        logic strap_prot;
        logic soft_prot;
        logic osc_off;
        logic stop_sel;
        logic src_lso;
        logic rst_mode;
    } ctrl_t;

    ctrl_t s_d, s_q;
    logic  wr_ctrl, wr_mode;

    always_comb begin
        wr_ctrl     = wr_en && (wr_addr == REG_CTRL);
        wr_mode     = wr_en && (wr_addr == REG_MODE);
        start_pulse = wr_en && (wr_addr == REG_START);
        protect     = s_q.strap_prot | s_q.soft_prot;
        prot_entry  = wr_mode && wr_bits[MODE_PROT] && !protect;

        s_d = s_q;
        if (wr_ctrl && !protect) begin
            s_d.osc_off  = wr_bits[CTRL_OSC_OFF];
            s_d.stop_sel = wr_bits[CTRL_STOP_SEL];
            s_d.src_lso  = wr_bits[CTRL_SRC_LSO];
        end
        if (wr_mode && !protect) begin
            s_d.rst_mode = wr_bits[MODE_RST];
        end
        if (prot_entry) begin
            s_d.soft_prot = 1'b1;
            s_d.osc_off   = 1'b0;
        end
        if (!rst_n) begin
            s_d.strap_prot = ~strap_prot_n;
            s_d.soft_prot  = 1'b0;
            s_d.osc_off    = 1'b0;
            s_d.stop_sel   = 1'b0;
            s_d.src_lso    = 1'b0;
            s_d.rst_mode   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign osc_off  = s_q.osc_off;
    assign stop_sel = s_q.stop_sel;
    assign src_lso  = s_q.src_lso;
    assign rst_mode = s_q.rst_mode;

    // R7: protection, once active, stays active until reset
    assert_prot_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        protect |=> protect);
    // R8: oscillator stays enabled whenever protection is active
    assert_osc_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        protect |-> !s_q.osc_off);
    // R8: stop selection cannot be changed under protection
    assert_stop_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        protect |=> $stable(s_q.stop_sel));
    // R9: response-mode bit cannot be changed under protection
    assert_mode_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        protect |=> $stable(s_q.rst_mode));
endmodule

// File: rtl/wdt_count_core.sv
module wdt_count_core #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap_start_n,
    input  logic             cpu_tick,
    input  logic             lso_tick,
    input  logic             use_lso,
    input  logic             start_i,
    input  logic             refresh_i,
    input  logic             force_i,
    input  logic             rst_mode_i,
    output logic [CNT_W-1:0] count_o,
    output logic             running_o,
    output logic             rst_req_o,
    output logic             irq_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             running;
        logic             rst_req;
        logic             irq;
    } core_t;

    core_t s_d, s_q;
    logic  tick;

    always_comb begin
        tick = use_lso ? lso_tick : cpu_tick;
        s_d = s_q;
        s_d.rst_req = 1'b0;
        s_d.irq     = 1'b0;
        if (start_i || force_i) begin
            s_d.running = 1'b1;
        end
        if (refresh_i || force_i) begin
            s_d.count = CNT_MAX;
        end else if (s_q.running && tick) begin
            if (s_q.count == '0) begin
                s_d.count   = CNT_MAX;
                s_d.rst_req = rst_mode_i;
                s_d.irq     = !rst_mode_i;
            end else begin
                s_d.count = s_q.count - 1'b1;
            end
        end
        if (!rst_n) begin
            s_d.count   = CNT_MAX;
            s_d.running = ~strap_start_n;
            s_d.rst_req = 1'b0;
            s_d.irq     = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign count_o   = s_q.count;
    assign running_o = s_q.running;
    assign rst_req_o = s_q.rst_req;
    assign irq_o     = s_q.irq;

    // R3: an accepted refresh leaves the counter at full scale
    assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_i |=> count_o == CNT_MAX);
    // R5: reset request is a single-cycle pulse
    assert_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> !rst_req_o);
    // R5: never both responses at once
    assert_one_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_req_o && irq_o));
    // R2: a stopped counter holds its value unless reloaded
    assert_stopped_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!running_o && !refresh_i && !force_i) |=> count_o == $past(count_o));
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
    import wdt_guard_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_start_n,
    input  logic              strap_prot_n,
    input  logic              cpu_tick,
    input  logic              lso_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  count,
    output logic              running,
    output logic              rst_req,
    output logic              uf_irq,
    output logic              protect_active,
    output logic              lso_en,
    output logic              stop_mode_en,
    output logic              rst_on_uf
);
    logic kick_refresh;
    logic prot, osc_off, stop_sel, src_lso, rst_mode, start_pulse, prot_entry;

    wdt_kick_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .refresh (kick_refresh)
    );

    wdt_ctrl_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .strap_prot_n (strap_prot_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_bits      (wr_data[CFG_BITS-1:0]),
        .protect      (prot),
        .osc_off      (osc_off),
        .stop_sel     (stop_sel),
        .src_lso      (src_lso),
        .rst_mode     (rst_mode),
        .start_pulse  (start_pulse),
        .prot_entry   (prot_entry)
    );

    wdt_count_core #(.CNT_W(CNT_W)) u_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .strap_start_n (strap_start_n),
        .cpu_tick      (cpu_tick),
        .lso_tick      (lso_tick),
        .use_lso       (prot | src_lso),
        .start_i       (start_pulse),
        .refresh_i     (kick_refresh),
        .force_i       (prot_entry),
        .rst_mode_i    (rst_mode | prot),
        .count_o       (count),
        .running_o     (running),
        .rst_req_o     (rst_req),
        .irq_o         (uf_irq)
    );

    assign protect_active = prot;
    assign lso_en         = ~osc_off;
    assign stop_mode_en   = stop_sel & ~prot;
    assign rst_on_uf      = rst_mode | prot;

    // R6: under protection the count moves only on an oscillator tick
    assert_src_forced_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (prot && !lso_tick && !kick_refresh) |=> count == $past(count));
    // R9: no interrupt-style underflow while protected
    assert_no_irq_prot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(prot) |-> !uf_irq);
endmodule

// File: tb/wdt_guard_test.sv
module wdt_guard_test;
    localparam int CNT_W = 12;
    localparam logic [CNT_W-1:0] FULL = 12'hFFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strap_start_n = 1'b0, strap_prot_n = 1'b1;
    logic cpu_tick = 1'b1, lso_tick = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [CNT_W-1:0] count;
    logic running, rst_req, uf_irq, protect_active, lso_en, stop_mode_en, rst_on_uf;

    always #2 clk = ~clk;

    wdt_guard #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .strap_start_n(strap_start_n), .strap_prot_n(strap_prot_n),
        .cpu_tick(cpu_tick), .lso_tick(lso_tick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .count(count), .running(running), .rst_req(rst_req),
        .uf_irq(uf_irq), .protect_active(protect_active), .lso_en(lso_en),
        .stop_mode_en(stop_mode_en), .rst_on_uf(rst_on_uf)
    );

    typedef struct { bit is_rst; int rel; } ev_t;
    ev_t sb[$];
    int cyc = 0;
    int base = 0;
    int n_checks = 0, n_fails = 0;
    int mon_checks = 0, mon_fails = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pops expected underflow events and compares
    always @(negedge clk) begin
        if (rst_n && (rst_req || uf_irq)) begin
            mon_checks = mon_checks + 1;
            if (sb.size() == 0) begin
                mon_fails = mon_fails + 1;
                $display("FAIL R5 unexpected event rst=%0d irq=%0d at rel %0d, expected none",
                         rst_req, uf_irq, cyc - base);
            end else begin
                ev_t e;
                e = sb.pop_front();
                if (e.is_rst != rst_req || e.rel != cyc - base || count != FULL) begin
                    mon_fails = mon_fails + 1;
                    $display("FAIL R5 event rst=%0d rel=%0d count=%h, expected rst=%0d rel=%0d count=%h",
                             rst_req, cyc - base, count, e.is_rst, e.rel, FULL);
                end
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_checks = n_checks + 1;
        if (act != exp) begin
            n_fails = n_fails + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic s_start, input logic s_prot);
        rst_n = 1'b0;
        strap_start_n = s_start;
        strap_prot_n = s_prot;
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_events(input string tag);
        for (int i = 0; i < 4200 && sb.size() != 0; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        check(tag, sb.size(), 0);
    endtask

    task automatic run_all;
        logic [CNT_W-1:0] c;
        // ---- auto start, no protection
        @(negedge clk);
        do_reset(1'b0, 1'b1);
        check("R1 count", count, FULL);
        check("R1 rst_req", rst_req, 0);
        check("R1 uf_irq", uf_irq, 0);
        check("R1 lso_en", lso_en, 1);
        check("R1 stop_mode_en", stop_mode_en, 0);
        check("R1 rst_on_uf", rst_on_uf, 1);
        check("R2 running auto", running, 1);
        @(negedge clk);
        check("R2 first decrement", count, FULL - 1);
        repeat (10) @(negedge clk);
        wr(2'd0, 8'h00); wr(2'd0, 8'hFF);
        check("R3 refresh pair", count, FULL);
        repeat (5) @(negedge clk);
        c = count; wr(2'd0, 8'hFF);
        check("R4 lone fire", count, c - 1);
        wr(2'd0, 8'h00); wr(2'd0, 8'h55);
        c = count; wr(2'd0, 8'hFF);
        check("R4 foreign value disarms", count, c - 1);
        wr(2'd0, 8'h00); wr(2'd3, 8'h01); wr(2'd0, 8'hFF);
        check("R3 other location keeps arm", count, FULL);
        repeat (4) @(negedge clk);
        wr(2'd0, 8'h00); wr(2'd0, 8'h00); wr(2'd0, 8'hFF);
        check("R3 doubled arm", count, FULL);
        strap_prot_n = 1'b0; strap_start_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 strap ignored protect", protect_active, 0);
        check("R10 strap ignored running", running, 1);
        strap_prot_n = 1'b1; strap_start_n = 1'b0;
        // underflow with reset response
        wr(2'd0, 8'h00); wr(2'd0, 8'hFF);
        base = cyc; sb.push_back('{1'b1, 4096});
        wait_events("R5 reset underflow");
        // underflow with interrupt response
        wr(2'd3, 8'h00);
        check("R9 writable unprotected", rst_on_uf, 0);
        wr(2'd0, 8'h00); wr(2'd0, 8'hFF);
        base = cyc; sb.push_back('{1'b0, 4096});
        wait_events("R5 irq underflow");
        // count source select
        wr(2'd2, 8'h04);
        c = count; repeat (5) @(negedge clk);
        check("R6 cpu tick ignored", count, c);
        lso_tick = 1'b1; @(negedge clk); lso_tick = 1'b0;
        check("R6 lso tick counts", count, c - 1);
        wr(2'd2, 8'h03);
        check("R8 osc off unprotected", lso_en, 0);
        check("R8 stop sel unprotected", stop_mode_en, 1);
        // soft protection entry
        wr(2'd3, 8'h02);
        check("R7 soft protect", protect_active, 1);
        check("R7 reload", count, FULL);
        check("R7 osc forced on", lso_en, 1);
        check("R8 stop masked", stop_mode_en, 0);
        check("R9 forced", rst_on_uf, 1);
        wr(2'd2, 8'h03);
        check("R8 ctrl write ignored", lso_en, 1);
        wr(2'd3, 8'h00);
        check("R7 sticky", protect_active, 1);
        check("R9 mode write ignored", rst_on_uf, 1);
        // ---- start on write
        do_reset(1'b1, 1'b1);
        check("R2 stopped after reset", running, 0);
        repeat (5) @(negedge clk);
        check("R2 holds full", count, FULL);
        wr(2'd1, 8'h5A);
        check("R2 start write", running, 1);
        check("R2 no decrement on start", count, FULL);
        base = cyc; sb.push_back('{1'b1, 4096});
        wait_events("R5 underflow after start");
        // ---- protection strap
        do_reset(1'b0, 1'b0);
        check("R7 strap protect", protect_active, 1);
        repeat (5) @(negedge clk);
        check("R6 cpu tick ignored protected", count, FULL);
        wr(2'd2, 8'h03);
        check("R8 osc stays on", lso_en, 1);
        check("R8 stop stays off", stop_mode_en, 0);
        wr(2'd3, 8'h00);
        check("R9 forced strap", rst_on_uf, 1);
        check("R6 writes no reload", count, FULL);
        lso_tick = 1'b1;
        base = cyc; sb.push_back('{1'b1, 4096});
        wait_events("R5 protected underflow");
        lso_tick = 1'b0;
    endtask

    initial begin
        bit timed_out;
        timed_out = 1'b0;
        fork
            run_all();
            begin
                repeat (200000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            n_checks = n_checks + 1;
            n_fails = n_fails + 1;
            $display("FAIL watchdog expired actual=hung expected=done");
        end
        $display("  [TB] %0d tests run, %0d failed", n_checks + mon_checks, n_fails + mon_fails);
        $finish;
    end
endmodule